// File: doc/BRIEF.md
# Time-Slotted Synchronous Serial Port

This block is a full-duplex synchronous serial port for audio and telecom converters. A transmit section and a receive section run at the same time. Each one follows its own bit clock and its own frame strobe. Words move most significant bit first, and the word length can be set anywhere from 8 to 32 bits. A frame strobe marks the start of slot 0. Words then follow back to back through `SLOTS` slots, and after the last slot the section goes idle until the next strobe arrives. A per-slot mask decides which slots the transmitter drives. In every other slot the data line is high-impedance, so several ports can share one wire in time-division fashion. A second mask decides which received slots are handed to the parallel side.

Each direction chooses its own bit clock source. It can use the internal clock, made by dividing the system clock and also driven out on a pin, or it can use a clock from an external pin. Every serial pin is resynchronised into the system clock domain, and the bit clock edges are found there. Transmit data changes on falling edges of the bit clock, and receive data is sampled on rising edges. The parallel side has one valid/ready word interface in each direction. Two one-cycle flags report a missing transmit word (underrun) and a received word that was not taken in time (overrun).

Top module: `ssp_tdm_port`

## Requirements
- R1: After reset, `tx_oe`, `tx_ws`, `tx_ready`, `rx_valid`, `tx_underrun` and `rx_overrun` are 0, and `tx_line` is high-impedance.
- R2: A word of `cfg_len` bits (8 to 32) is sent from bit `cfg_len-1` of `tx_data` down to bit 0. A received word appears in the low `cfg_len` bits of `rx_data`, and all higher bits are zero.
- R3: A frame strobe sampled high on a rising bit clock edge means that the next bit is bit 0 of slot 0. Slots 0 to `SLOTS-1` follow without gaps. After that the section stays idle: no line drive and no received words until another strobe comes.
- R4: The transmitter drives `tx_line` (with `tx_oe`=1) only during slots whose bit is set in `cfg_tx_mask`. In every other slot, and when idle, `tx_oe`=0 and `tx_line` is high-impedance.
- R5: A received word is presented only when its slot's bit is set in `cfg_rx_mask`, and `rx_slot` then gives that slot's number.
- R6: Transmit bits change after falling bit clock edges and receive bits are sampled on rising edges, so the transmit line looped back to the receive input returns every word unchanged.
- R7: With the internal source selected, the bit clock is `sclk_o`, whose half period is `cfg_div+1` system cycles (`cfg_div` ≥ 1). With the external source selected (`cfg_tx_ext`/`cfg_rx_ext` = 1), the section follows `tx_bclk`/`rx_bclk`. The two directions choose their sources independently, and an unselected pin has no effect.
- R8: If `tx_valid` is low when a masked slot begins, that slot carries all zeros and `tx_underrun` pulses for one cycle.
- R9: If a new word completes while `rx_valid` is high and `rx_ready` is low, the new word replaces the old one, `rx_valid` stays high and `rx_overrun` pulses for one cycle.
- R10: `tx_ready` is a one-cycle pulse at the start of each masked slot, and a word is taken when `tx_valid` and `tx_ready` are both high.
- R11: `tx_ws` is high during the first bit of each driven word and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W | Word length in bits, 8 to W |
| cfg_div | input | DIV_W | Internal bit clock half period minus one, in system cycles |
| cfg_tx_ext | input | 1 | Transmit uses the external bit clock when 1 |
| cfg_rx_ext | input | 1 | Receive uses the external bit clock when 1 |
| cfg_tx_mask | input | SLOTS | Slots the transmitter drives |
| cfg_rx_mask | input | SLOTS | Slots the receiver delivers |
| sclk_o | output | 1 | Internal bit clock |
| tx_bclk | input | 1 | External transmit bit clock |
| tx_fs | input | 1 | Transmit frame strobe |
| tx_line | output | 1 | Serial transmit data, high-impedance when not driven |
| tx_oe | output | 1 | Transmit line enable |
| tx_ws | output | 1 | Word-sync strobe on the first bit of a driven word |
| rx_bclk | input | 1 | External receive bit clock |
| rx_fs | input | 1 | Receive frame strobe |
| rx_sd | input | 1 | Serial receive data |
| tx_data | input | W | Word to transmit |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_underrun | output | 1 | Masked slot began without a word |
| rx_data | output | W | Received word |
| rx_slot | output | SLOT_W | Slot number of the received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Receiver side takes the word |
| rx_overrun | output | 1 | Pending word was overwritten |

## Verification
Each serial pin goes through two synchroniser stages, and the edge is found in a third. The transmit line and `tx_ws` therefore move about three to four system cycles after a bit clock fall that the bench sees, and `rx_valid` rises about four cycles after the rising edge that carries a word's last bit. The bench probes line state five system cycles after each bit clock fall it counts, which is well inside a bit period of eight or more cycles. Received words are not expected at a fixed cycle. They are popped from a scoreboard whenever `rx_valid` and `rx_ready` are both high. The queue is checked for emptiness only after a whole frame plus margin has passed, and pulse counters are read at that same point.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {CLK_INT = 1'b0, CLK_EXT = 1'b1} clk_src_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             sclk
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_pinsync.sv
module ssp_pinsync #(
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk,
  input  logic [DW-1:0] din,
  output logic          rise,
  output logic          fall,
  output logic [DW-1:0] dout
);
  logic [1:0]    c_meta;
  logic          c_last;
  logic [DW-1:0] d_meta [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      c_meta <= '0;
      c_last <= 1'b0;
    end else begin
      c_meta <= {c_meta[0], bclk};
      c_last <= c_meta[1];
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) d_meta[s] <= '0;
      else     d_meta[s] <= (s == 0) ? din : d_meta[0];
    end
  end

  assign rise = c_meta[1] & ~c_last;
  assign fall = ~c_meta[1] & c_last;
  assign dout = d_meta[1];
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int W      = 32,
  parameter int SLOTS  = 8,
  parameter int LEN_W  = 6,
  parameter int SLOT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             b_rise,
  input  logic             b_fall,
  input  logic             fs,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [SLOTS-1:0] cfg_mask,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             sd,
  output logic             oe,
  output logic             ws,
  output logic             underrun
);
  logic              go;
  logic [LEN_W-1:0]  bitcnt;
  logic [SLOT_W-1:0] slot;
  logic [W-1:0]      shreg;
  logic              word_start;

  assign word_start = b_fall && go && (bitcnt == '0);
  assign tx_ready   = word_start && cfg_mask[slot];
  assign sd         = shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      go       <= 1'b0;
      bitcnt   <= '0;
      slot     <= '0;
      shreg    <= '0;
      oe       <= 1'b0;
      ws       <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (b_rise && fs) begin
        go     <= 1'b1;
        bitcnt <= '0;
        slot   <= '0;
      end else if (b_fall) begin
        if (go) begin
          if (word_start) begin
            oe <= cfg_mask[slot];
            ws <= cfg_mask[slot];
            if (cfg_mask[slot]) begin
              shreg    <= tx_valid ? (tx_data << (W - int'(cfg_len))) : '0;
              underrun <= ~tx_valid;
            end
          end else begin
            shreg <= shreg << 1;
            ws    <= 1'b0;
          end
          if (bitcnt == cfg_len - 1'b1) begin
            bitcnt <= '0;
            if (slot == SLOT_W'(SLOTS - 1)) go <= 1'b0;
            else                            slot <= slot + 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end else begin
          oe <= 1'b0;
          ws <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int W      = 32,
  parameter int SLOTS  = 8,
  parameter int LEN_W  = 6,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              b_rise,
  input  logic              fs,
  input  logic              sd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [SLOTS-1:0]  cfg_mask,
  output logic [W-1:0]      rx_data,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              overrun
);
  logic              go;
  logic [LEN_W-1:0]  bitcnt;
  logic [SLOT_W-1:0] slot;
  logic [W-1:0]      shreg;
  logic [W-1:0]      next_word;

  assign next_word = (bitcnt == '0) ? {{(W-1){1'b0}}, sd} : {shreg[W-2:0], sd};

  always_ff @(posedge clk) begin
    if (rst) begin
      go       <= 1'b0;
      bitcnt   <= '0;
      slot     <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_slot  <= '0;
      rx_valid <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (b_rise && fs) begin
        go     <= 1'b1;
        bitcnt <= '0;
        slot   <= '0;
      end else if (b_rise && go) begin
        shreg <= next_word;
        if (bitcnt == cfg_len - 1'b1) begin
          bitcnt <= '0;
          if (cfg_mask[slot]) begin
            rx_data  <= next_word;
            rx_slot  <= slot;
            rx_valid <= 1'b1;
            overrun  <= rx_valid && !rx_ready;
          end
          if (slot == SLOT_W'(SLOTS - 1)) go <= 1'b0;
          else                            slot <= slot + 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_tdm_port.sv
module ssp_tdm_port #(
  parameter  int W      = 32,
  parameter  int SLOTS  = 8,
  parameter  int DIV_W  = 8,
  localparam int LEN_W  = $clog2(W + 1),
  localparam int SLOT_W = ssp_pkg::idx_w(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_tx_ext,
  input  logic              cfg_rx_ext,
  input  logic [SLOTS-1:0]  cfg_tx_mask,
  input  logic [SLOTS-1:0]  cfg_rx_mask,
  output logic              sclk_o,
  input  logic              tx_bclk,
  input  logic              tx_fs,
  output logic              tx_line,
  output logic              tx_oe,
  output logic              tx_ws,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_sd,
  input  logic [W-1:0]      tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_underrun,
  output logic [W-1:0]      rx_data,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_overrun
);
  import ssp_pkg::*;

  clk_src_e tx_src, rx_src;
  logic     tx_clk_sel, rx_clk_sel;
  logic     tx_rise, tx_fall, rx_rise, rx_fall_unused;
  logic     tx_fs_s, tx_bit;
  logic [1:0] rx_pins_s;

  assign tx_src     = clk_src_e'(cfg_tx_ext);
  assign rx_src     = clk_src_e'(cfg_rx_ext);
  assign tx_clk_sel = (tx_src == CLK_EXT) ? tx_bclk : sclk_o;
  assign rx_clk_sel = (rx_src == CLK_EXT) ? rx_bclk : sclk_o;

  ssp_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(cfg_div), .sclk(sclk_o)
  );

  ssp_pinsync #(.DW(1)) u_tx_sync (
    .clk(clk), .rst(rst), .bclk(tx_clk_sel), .din(tx_fs),
    .rise(tx_rise), .fall(tx_fall), .dout(tx_fs_s)
  );

  ssp_pinsync #(.DW(2)) u_rx_sync (
    .clk(clk), .rst(rst), .bclk(rx_clk_sel), .din({rx_fs, rx_sd}),
    .rise(rx_rise), .fall(rx_fall_unused), .dout(rx_pins_s)
  );

  ssp_tx #(.W(W), .SLOTS(SLOTS), .LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .b_rise(tx_rise), .b_fall(tx_fall), .fs(tx_fs_s),
    .cfg_len(cfg_len), .cfg_mask(cfg_tx_mask), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .sd(tx_bit), .oe(tx_oe),
    .ws(tx_ws), .underrun(tx_underrun)
  );

  ssp_rx #(.W(W), .SLOTS(SLOTS), .LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .b_rise(rx_rise), .fs(rx_pins_s[1]), .sd(rx_pins_s[0]),
    .cfg_len(cfg_len), .cfg_mask(cfg_rx_mask), .rx_data(rx_data),
    .rx_slot(rx_slot), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .overrun(rx_overrun)
  );

  assign tx_line = tx_oe ? tx_bit : 1'bz;
endmodule

// File: rtl/ssp_tdm_port_chk.sv
module ssp_tdm_port_chk #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_oe,
  input logic              tx_ws,
  input logic              tx_ready,
  input logic              tx_underrun,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_overrun,
  input logic [SLOT_W-1:0] rx_slot,
  input logic [SLOTS-1:0]  cfg_rx_mask
);
  AST_WS_WITH_OE: assert property (@(posedge clk) disable iff (rst) tx_ws |-> tx_oe); // R11
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) tx_ready |=> !tx_ready); // R10
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst) tx_underrun |=> !tx_underrun); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst) (rx_valid && !rx_ready) |=> rx_valid); // R9
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst) rx_overrun |-> $past(rx_valid && !rx_ready)); // R9
  AST_RX_SLOT_MASKED: assert property (@(posedge clk) disable iff (rst) rx_valid |-> cfg_rx_mask[rx_slot]); // R5
endmodule

bind ssp_tdm_port ssp_tdm_port_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_oe(tx_oe), .tx_ws(tx_ws), .tx_ready(tx_ready),
  .tx_underrun(tx_underrun), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_overrun(rx_overrun), .rx_slot(rx_slot), .cfg_rx_mask(cfg_rx_mask)
);

// File: tb/ssp_tdm_port_tb.sv
module ssp_tdm_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int SLOTS = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] cfg_len = 6'd8;
  logic [7:0] cfg_div = 8'd3;
  logic cfg_tx_ext = 1'b0, cfg_rx_ext = 1'b0;
  logic [SLOTS-1:0] cfg_tx_mask = '0, cfg_rx_mask = '0;
  logic sclk_o, tx_line, tx_oe, tx_ws, tx_ready, tx_underrun;
  logic [W-1:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, rx_ready = 1'b1, rx_valid, rx_overrun;
  logic [2:0] rx_slot;
  logic ext_clk = 1'b0, fs = 1'b0, rx_from_int = 1'b0;
  logic rx_bclk_pin, rx_sd, bref;

  int checks = 0, errors = 0, rx_cnt = 0, ready_cnt = 0, und_cnt = 0, ovr_cnt = 0;
  bit done = 0;
  logic [39:0] exp_q[$];

  assign rx_bclk_pin = rx_from_int ? sclk_o : ext_clk;
  assign rx_sd = tx_oe ? tx_line : 1'b0;
  assign bref = cfg_tx_ext ? ext_clk : sclk_o;

  ssp_tdm_port #(.W(W), .SLOTS(SLOTS), .DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_div(cfg_div),
    .cfg_tx_ext(cfg_tx_ext), .cfg_rx_ext(cfg_rx_ext),
    .cfg_tx_mask(cfg_tx_mask), .cfg_rx_mask(cfg_rx_mask), .sclk_o(sclk_o),
    .tx_bclk(ext_clk), .tx_fs(fs), .tx_line(tx_line), .tx_oe(tx_oe), .tx_ws(tx_ws),
    .rx_bclk(rx_bclk_pin), .rx_fs(fs), .rx_sd(rx_sd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_underrun(tx_underrun), .rx_data(rx_data), .rx_slot(rx_slot),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CLK_PERIOD*5) ext_clk = ~ext_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] wgen(input int f, input int s);
    return (32'h9E37_79B9 * (f * 8 + s + 1)) ^ 32'h8000_0001;
  endfunction

  // monitor: scoreboard pops and pulse counters
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_ready) ready_cnt++;
      if (tx_underrun) und_cnt++;
      if (rx_overrun) ovr_cnt++;
      if (rx_valid && rx_ready) begin
        rx_cnt++;
        if (exp_q.size() == 0)
          chk(0, "R5", "unexpected word", {5'd0, rx_slot, rx_data}, 0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk({5'd0, rx_slot, rx_data} == e, "R2 R5 R6", "looped word",
              {5'd0, rx_slot, rx_data}, e);
        end
      end
    end
  end

  task automatic send(input logic [31:0] w, input int s, input int len, input bit push);
    tx_data = w;
    tx_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    if (push) exp_q.push_back({s[7:0], w & lmask(len)});
    @(negedge clk);
  endtask

  task automatic run_frame(input int len, input logic [7:0] mask, input bit feed,
                           input bit only_last, input int fno);
    int last_s = 0;
    for (int s = 0; s < SLOTS; s++) if (mask[s]) last_s = s;
    fork
      begin @(negedge bref); fs = 1'b1; @(negedge bref); fs = 1'b0; end
      begin
        for (int s = 0; s < SLOTS; s++) begin
          if (mask[s]) begin
            if (feed) send(wgen(fno, s), s, len, !only_last || s == last_s);
            else exp_q.push_back({s[7:0], 32'd0});
          end
        end
        tx_valid = 1'b0;
      end
    join
    repeat (len * SLOTS + 4) @(negedge bref);
    repeat (10) @(posedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R3", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    realtime t0;
    int c0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(tx_oe == 0 && tx_ws == 0 && tx_ready == 0, "R1", "tx outputs in reset",
        {tx_oe, tx_ws, tx_ready}, 0);
    chk(tx_line === 1'bz, "R1", "line tri-stated in reset", tx_line, 0);
    chk(rx_valid == 0 && tx_underrun == 0 && rx_overrun == 0, "R1", "rx/flags in reset",
        {rx_valid, tx_underrun, rx_overrun}, 0);
    rst = 1'b0;

    // R7: divider period
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o);
    chk(($realtime - t0) == 8.0 * CLK_PERIOD, "R7", "internal bit period",
        longint'(($realtime - t0) / CLK_PERIOD), 8);

    // T2: internal clock, 8-bit words, slots 0 and 2
    cfg_len = 6'd8; cfg_tx_mask = 8'b0000_0101; cfg_rx_mask = 8'b0000_0101;
    fork
      run_frame(8, 8'b0000_0101, 1, 0, 1);
      begin
        @(posedge fs);
        @(negedge bref); repeat (5) @(posedge clk);
        chk(tx_ws == 1 && tx_oe == 1, "R11", "ws on first bit", {tx_ws, tx_oe}, 3);
        @(negedge bref); repeat (5) @(posedge clk);
        chk(tx_ws == 0 && tx_oe == 1, "R11", "ws low on second bit", {tx_ws, tx_oe}, 1);
        repeat (8 + 4 - 1) @(negedge bref); repeat (5) @(posedge clk);
        chk(tx_oe == 0 && tx_line === 1'bz, "R4", "unmasked slot 1 tri-stated", tx_oe, 0);
      end
    join
    chk(exp_q.size() == 0, "R3", "frame drained (len 8)", exp_q.size(), 0);
    chk(und_cnt == 0, "R8", "no underrun when fed", und_cnt, 0);

    // T3: 32-bit words, first and last slot
    cfg_len = 6'd32; cfg_tx_mask = 8'b1000_0001; cfg_rx_mask = 8'b1000_0001;
    ready_cnt = 0;
    run_frame(32, 8'b1000_0001, 1, 0, 2);
    chk(exp_q.size() == 0, "R3", "frame drained (len 32)", exp_q.size(), 0);
    chk(ready_cnt == 2, "R10", "one ready per masked slot", ready_cnt, 2);
    c0 = rx_cnt;
    repeat (64) @(negedge bref);
    @(negedge clk);
    chk(rx_cnt == c0 && tx_oe == 0, "R3", "idle after last slot", rx_cnt - c0, 0);

    // T4: external clocks both directions, 13-bit words, tx/rx masks differ
    cfg_tx_ext = 1'b1; cfg_rx_ext = 1'b1; rx_from_int = 1'b0;
    cfg_len = 6'd13; cfg_tx_mask = 8'b0101_0010; cfg_rx_mask = 8'b0101_0010;
    repeat (20) @(posedge clk);
    run_frame(13, 8'b0101_0010, 1, 0, 3);
    chk(exp_q.size() == 0, "R7", "external clock frame drained", exp_q.size(), 0);

    // T5: tx internal (tx_bclk pin toggling but unselected), rx external fed from sclk_o
    cfg_tx_ext = 1'b0; cfg_rx_ext = 1'b1; rx_from_int = 1'b1;
    cfg_len = 6'd16; cfg_tx_mask = 8'b0000_1110; cfg_rx_mask = 8'b0000_1010;
    repeat (20) @(posedge clk);
    fork
      begin
        @(posedge fs);
        for (int s = 0; s < SLOTS; s++) if (cfg_tx_mask[s]) begin
          send(wgen(4, s), s, 16, cfg_rx_mask[s]);
        end
        tx_valid = 1'b0;
      end
      begin @(negedge bref); fs = 1'b1; @(negedge bref); fs = 1'b0; end
    join
    repeat (16 * SLOTS + 4) @(negedge bref);
    repeat (10) @(posedge clk);
    chk(exp_q.size() == 0, "R5", "only rx-masked slots delivered", exp_q.size(), 0);
    chk(rx_cnt == c0 + 3 + 2, "R7", "independent source words", rx_cnt, c0 + 5);

    // T6: underrun
    cfg_rx_ext = 1'b0; rx_from_int = 1'b0;
    cfg_len = 6'd8; cfg_tx_mask = 8'b0000_0011; cfg_rx_mask = 8'b0000_0011;
    und_cnt = 0;
    run_frame(8, 8'b0000_0011, 0, 0, 5);
    chk(und_cnt == 2, "R8", "underrun pulses", und_cnt, 2);
    chk(exp_q.size() == 0, "R8", "zero words drained", exp_q.size(), 0);

    // T7: overrun
    rx_ready = 1'b0; ovr_cnt = 0;
    run_frame(8, 8'b0000_0011, 1, 1, 6);
    chk(ovr_cnt == 1, "R9", "overrun pulse", ovr_cnt, 1);
    chk(rx_valid == 1, "R9", "valid held", rx_valid, 1);
    @(negedge clk); rx_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "newer word kept", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule